// File: doc/BRIEF.md
# Dual-Tone Multifrequency Sample Synthesizer

This block turns a 5-bit tone code into a stream of signed 12-bit digital samples for a telephone-signalling tone path. Each sample is one of three things: the sum of a low-group (row) sinusoid and a high-group (column) sinusoid, a single sinusoid from either group, or silence. Two 24-bit phase accumulators advance once per sample frame. A single quarter-wave sine table serves both tones, one after the other within the frame. Each looked-up value is scaled by a fixed gain per group. The column gain is about 2 dB above the row gain, which gives the high group its pre-emphasis.

The system clock is nominally 3.579545 MHz. A frame counter divides it by `SAMPLE_DIV`, and each frame yields one sample together with a single-cycle valid strobe. A code is presented with a load strobe. It takes effect at the start of the next frame, and at that point both phases restart from zero, so every tone burst starts the same way. When the enable is low the samples are forced to zero while the strobe keeps its cadence.

Top module: `dtmf_synth`

## Requirements
- R1: With code bit 4 at 0, the low nibble selects a row/column pair (row index 0..3 = 697/770/852/941 Hz, column index 0..3 = 1209/1336/1477/1633 Hz). 0001..1001 give the rows 0..2 by columns 0..2 in row-major order. 1010 gives r3c1, 1011 gives r3c0, 1100 gives r3c2, 1101..1111 give r0c3, r1c3, r2c3, and 0000 gives r3c3. Each dual-tone sample equals the sum of the matching row-only and column-only samples at the same frame index after load.
- R2: Codes 10000..10011 produce only the row tone of index code[1:0].
- R3: Codes 10100..10111 produce only the column tone of index code[1:0].
- R4: Code 11111 and the unused codes 11000..11110 produce all-zero samples.
- R5: Each produced tone's frequency is within 0.75 % of its nominal value.
- R6: The row-only peak magnitude lies in 880..901 and the column-only peak in 1110..1134. The column/row peak ratio lies between 1.122 and 1.413, which is 1 to 3 dB.
- R7: Every sample lies within ±2035, so the row plus the pre-emphasized column never overflows the 12-bit output.
- R8: `valid_o` is a single-cycle pulse every `SAMPLE_DIV` clocks, and `sample_o` changes only together with it.
- R9: A code loaded after one valid pulse governs the next sample. Both phases restart at zero, so that first sample is 0.
- R10: A sample produced while `en_i` is low is zero, and valid pulses continue. On re-enable the tone restarts from zero phase.
- R11: After reset, `sample_o` and `valid_o` are 0 and the active code is silence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Output enable; low forces zero samples |
| load_i | input | 1 | One-cycle strobe that captures `code_i` |
| code_i | input | 5 | Tone code |
| sample_o | output | 12 | Signed two's-complement sample |
| valid_o | output | 1 | Pulses for one cycle with each new sample |

## Verification
Every frame exposes the state of the phases and the decoder through its sample. A wrong decode or a wrong pairing therefore breaks the row-plus-column identity from the second sample after a load. A wrong phase step moves the zero crossings, which shows within about one period of the slowest tone. A phase that is not cleared on load or re-enable shows at once, because the first sample is then non-zero. A wrong gain shows as a peak outside the stated bands within one period. A cadence fault shows at the very next strobe.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    typedef struct packed {
        logic       row_on;
        logic       col_on;
        logic [1:0] row_idx;
        logic [1:0] col_idx;
    } tone_sel_t;

    function automatic int unsigned row_hz(input int unsigned idx);
        case (idx)
            0:       return 697;
            1:       return 770;
            2:       return 852;
            default: return 941;
        endcase
    endfunction

    function automatic int unsigned col_hz(input int unsigned idx);
        case (idx)
            0:       return 1209;
            1:       return 1336;
            2:       return 1477;
            default: return 1633;
        endcase
    endfunction

    // Nearest integer phase increment for a tone at the frame rate clk_hz/div
    function automatic longint unsigned phase_step(input longint unsigned hz,
                                                   input longint unsigned div,
                                                   input longint unsigned clk_hz,
                                                   input int unsigned     pw);
        return (((hz * div) << pw) + clk_hz / 2) / clk_hz;
    endfunction

endpackage

// File: rtl/dtmf_code_decode.sv
module dtmf_code_decode
    import dtmf_pkg::*;
(
    input  logic [4:0] code_i,
    output tone_sel_t  sel_o
);

    always_comb begin
        sel_o = '0;
        if (!code_i[4]) begin
            sel_o.row_on = 1'b1;
            sel_o.col_on = 1'b1;
            case (code_i[3:0])
                4'b0001: begin sel_o.row_idx = 2'd0; sel_o.col_idx = 2'd0; end
                4'b0010: begin sel_o.row_idx = 2'd0; sel_o.col_idx = 2'd1; end
                4'b0011: begin sel_o.row_idx = 2'd0; sel_o.col_idx = 2'd2; end
                4'b0100: begin sel_o.row_idx = 2'd1; sel_o.col_idx = 2'd0; end
                4'b0101: begin sel_o.row_idx = 2'd1; sel_o.col_idx = 2'd1; end
                4'b0110: begin sel_o.row_idx = 2'd1; sel_o.col_idx = 2'd2; end
                4'b0111: begin sel_o.row_idx = 2'd2; sel_o.col_idx = 2'd0; end
                4'b1000: begin sel_o.row_idx = 2'd2; sel_o.col_idx = 2'd1; end
                4'b1001: begin sel_o.row_idx = 2'd2; sel_o.col_idx = 2'd2; end
                4'b1010: begin sel_o.row_idx = 2'd3; sel_o.col_idx = 2'd1; end
                4'b1011: begin sel_o.row_idx = 2'd3; sel_o.col_idx = 2'd0; end
                4'b1100: begin sel_o.row_idx = 2'd3; sel_o.col_idx = 2'd2; end
                4'b1101: begin sel_o.row_idx = 2'd0; sel_o.col_idx = 2'd3; end
                4'b1110: begin sel_o.row_idx = 2'd1; sel_o.col_idx = 2'd3; end
                4'b1111: begin sel_o.row_idx = 2'd2; sel_o.col_idx = 2'd3; end
                default: begin sel_o.row_idx = 2'd3; sel_o.col_idx = 2'd3; end
            endcase
        end else if (!code_i[3]) begin
            // single-tone group: bit 2 picks column group, low bits the index
            sel_o.row_on  = !code_i[2];
            sel_o.col_on  = code_i[2];
            sel_o.row_idx = code_i[1:0];
            sel_o.col_idx = code_i[1:0];
        end
    end

endmodule

// File: rtl/dtmf_sine_rom.sv
module dtmf_sine_rom #(
    parameter int unsigned QTR_BITS = 6,
    parameter int unsigned AMP      = 1023,
    parameter int unsigned VAL_W    = 11
) (
    input  logic [QTR_BITS+1:0]      phase_i,
    output logic signed [VAL_W-1:0]  value_o
);

    localparam int unsigned N      = 1 << QTR_BITS;
    localparam int unsigned ENT    = N + 1;
    localparam int unsigned ADDR_W = QTR_BITS + 1;

    function automatic logic [ENT*VAL_W-1:0] build_tab();
        logic [ENT*VAL_W-1:0] t;
        real                  r;
        t = '0;
        for (int i = 0; i < int'(ENT); i++) begin
            r = real'(AMP) * $sin(3.14159265358979 / 2.0 * real'(i) / real'(N));
            t[i*VAL_W +: VAL_W] = VAL_W'($rtoi(r + 0.5));
        end
        return t;
    endfunction

    localparam logic [ENT*VAL_W-1:0] TAB = build_tab();

    logic [1:0]          quad;
    logic [QTR_BITS-1:0] idx;
    logic [ADDR_W-1:0]   addr;
    logic [VAL_W-1:0]    mag;

    always_comb begin
        quad    = phase_i[QTR_BITS+1:QTR_BITS];
        idx     = phase_i[QTR_BITS-1:0];
        addr    = quad[0] ? (ADDR_W'(N) - {1'b0, idx}) : {1'b0, idx};
        mag     = TAB[int'(addr)*VAL_W +: VAL_W];
        value_o = quad[1] ? -$signed(mag) : $signed(mag);
    end

endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
    import dtmf_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 3579545,
    parameter int unsigned SAMPLE_DIV = 448,
    parameter int unsigned PHASE_W    = 24,
    parameter int unsigned QTR_BITS   = 6,
    parameter int unsigned SINE_AMP   = 1023,
    parameter int unsigned ROW_GAIN   = 901,
    parameter int unsigned COL_GAIN   = 1135,
    parameter int unsigned GAIN_SHIFT = 10,
    parameter int unsigned OUT_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    load_i,
    input  logic [4:0]              code_i,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    valid_o
);

    localparam int unsigned CNT_W    = $clog2(SAMPLE_DIV);
    localparam int unsigned SINE_W   = $clog2(SINE_AMP + 1) + 1;
    localparam int unsigned GAIN_W   = $clog2(COL_GAIN + 1) + 1;
    localparam int unsigned PROD_W   = SINE_W + GAIN_W;
    localparam int unsigned LUT_W    = QTR_BITS + 2;
    localparam logic [4:0]  CODE_OFF = 5'b11111;

    typedef struct packed {
        logic [CNT_W-1:0]        cnt;
        logic [4:0]              code;
        logic                    pend;
        logic [4:0]              pend_code;
        logic [PHASE_W-1:0]      acc_row;
        logic [PHASE_W-1:0]      acc_col;
        logic signed [OUT_W-1:0] row_val;
        logic signed [OUT_W-1:0] sample;
        logic                    valid;
    } state_t;

    state_t st_d, st_q;

    logic [PHASE_W-1:0] row_inc_tab [4];
    logic [PHASE_W-1:0] col_inc_tab [4];

    for (genvar g = 0; g < 4; g++) begin : g_inc
        localparam logic [PHASE_W-1:0] ROW_STEP =
            PHASE_W'(phase_step(row_hz(g), SAMPLE_DIV, SYS_CLK_HZ, PHASE_W));
        localparam logic [PHASE_W-1:0] COL_STEP =
            PHASE_W'(phase_step(col_hz(g), SAMPLE_DIV, SYS_CLK_HZ, PHASE_W));
        assign row_inc_tab[g] = ROW_STEP;
        assign col_inc_tab[g] = COL_STEP;
    end

    tone_sel_t sel;

    dtmf_code_decode u_dec (
        .code_i (st_q.code),
        .sel_o  (sel)
    );

    // one table, row looked up in frame slot 1, column in slot 2
    logic                     row_slot;
    logic [LUT_W-1:0]         lut_phase;
    logic signed [SINE_W-1:0] sine_val;

    assign row_slot  = (st_q.cnt == CNT_W'(1));
    assign lut_phase = row_slot ? st_q.acc_row[PHASE_W-1 -: LUT_W]
                                : st_q.acc_col[PHASE_W-1 -: LUT_W];

    dtmf_sine_rom #(
        .QTR_BITS (QTR_BITS),
        .AMP      (SINE_AMP),
        .VAL_W    (SINE_W)
    ) u_rom (
        .phase_i (lut_phase),
        .value_o (sine_val)
    );

    logic [GAIN_W-1:0]        gain;
    logic [PROD_W-1:0]        prod_raw;
    logic signed [PROD_W-1:0] prod_shr;
    logic signed [OUT_W-1:0]  scaled;

    always_comb begin
        if (row_slot) gain = sel.row_on ? GAIN_W'(ROW_GAIN) : '0;
        else          gain = sel.col_on ? GAIN_W'(COL_GAIN) : '0;
        prod_raw = {{GAIN_W{sine_val[SINE_W-1]}}, sine_val} * {{SINE_W{1'b0}}, gain};
        prod_shr = $signed(prod_raw) >>> GAIN_SHIFT;
        scaled   = prod_shr[OUT_W-1:0];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.cnt   = (st_q.cnt == CNT_W'(SAMPLE_DIV - 1)) ? '0 : st_q.cnt + CNT_W'(1);

        if (st_q.cnt == '0) begin
            if (load_i || st_q.pend) begin
                st_d.code    = load_i ? code_i : st_q.pend_code;
                st_d.pend    = 1'b0;
                st_d.acc_row = '0;
                st_d.acc_col = '0;
            end
        end else if (load_i) begin
            st_d.pend      = 1'b1;
            st_d.pend_code = code_i;
        end

        if (row_slot) st_d.row_val = scaled;

        if (st_q.cnt == CNT_W'(2)) begin
            st_d.valid = 1'b1;
            if (en_i) begin
                st_d.sample  = st_q.row_val + scaled;
                st_d.acc_row = st_q.acc_row + row_inc_tab[sel.row_idx];
                st_d.acc_col = st_q.acc_col + col_inc_tab[sel.col_idx];
            end else begin
                st_d.sample  = '0;
                st_d.acc_row = '0;
                st_d.acc_col = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= CODE_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = st_q.sample;
    assign valid_o  = st_q.valid;

endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk #(
    parameter int unsigned SAMPLE_DIV = 448,
    parameter int unsigned OUT_W      = 12,
    parameter int          PEAK       = 2036
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en_i,
    input logic signed [OUT_W-1:0] sample_o,
    input logic                    valid_o
);

    localparam int unsigned GAP_W = $clog2(SAMPLE_DIV + 1) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (valid_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    p_valid_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && seen_q) |-> (gap_q == GAP_W'(SAMPLE_DIV - 1)));

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_sample_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(sample_o));

    p_disabled_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !$past(en_i)) |-> (sample_o == '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((int'(sample_o) <= PEAK) && (int'(sample_o) >= -PEAK)));

endmodule

bind dtmf_synth dtmf_synth_chk #(
    .SAMPLE_DIV (SAMPLE_DIV),
    .OUT_W      (OUT_W),
    .PEAK       (int'(ROW_GAIN + COL_GAIN))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .sample_o (sample_o),
    .valid_o  (valid_o)
);

// File: tb/dtmf_synth_test.sv
module dtmf_synth_test;

    localparam int  CLK_PERIOD = 10;
    localparam int  DIV        = 8;
    localparam int  CAP_N      = 1600;
    localparam int  REC_N      = 256;
    localparam real FS         = 3579545.0 / 8.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_i = 1'b1;
    logic              load_i = 1'b0;
    logic [4:0]        code_i = 5'b11111;
    logic signed [11:0] sample_o;
    logic              valid_o;

    dtmf_synth #(.SAMPLE_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .load_i(load_i),
        .code_i(code_i), .sample_o(sample_o), .valid_o(valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int mode = 0;          // 0 ignore, 1 capture, 2 compare
    int cap [CAP_N];
    int cap_idx = 0;
    int exp_q [$];
    int row_rec [4][REC_N];
    int col_rec [4][REC_N];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop and capture on each valid sample
    initial begin
        forever begin
            @(negedge clk);
            if (valid_o) begin
                if (mode == 1 && cap_idx < CAP_N) begin
                    cap[cap_idx] = int'(sample_o);
                    cap_idx++;
                end else if (mode == 2 && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(sample_o) == e, "R1/R4/R9/R10 sample", int'(sample_o), e);
                end
            end
        end
    end

    task automatic load_code(input logic [4:0] c);
        do @(negedge clk); while (!valid_o);
        load_i = 1'b1;
        code_i = c;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic run_compare();
        mode = 2;
        wait (exp_q.size() == 0);
        mode = 0;
    endtask

    // R2/R3/R5/R6/R9 single-tone capture and analysis
    task automatic single_tone(input logic [4:0] c, input bit is_col, input int idx, input real hz);
        int  first_x, last_x, nx, pk;
        real f_est, err;
        load_code(c);
        cap_idx = 0;
        mode    = 1;
        wait (cap_idx == CAP_N);
        mode    = 0;
        check(cap[0] == 0, "R9 first sample zero", cap[0], 0);
        first_x = -1; last_x = -1; nx = 0; pk = 0;
        for (int k = 0; k < CAP_N; k++) begin
            if (k > 0 && cap[k-1] < 0 && cap[k] >= 0) begin
                if (first_x < 0) first_x = k;
                last_x = k;
                nx++;
            end
            if (cap[k] > pk) pk = cap[k];
            if (-cap[k] > pk) pk = -cap[k];
            if (k < REC_N) begin
                if (is_col) col_rec[idx][k] = cap[k];
                else        row_rec[idx][k] = cap[k];
            end
        end
        check(nx >= 2, is_col ? "R3 crossings" : "R2 crossings", nx, 2);
        if (nx >= 2) begin
            f_est = real'(nx - 1) * FS / real'(last_x - first_x);
            err   = (f_est - hz) / hz;
            if (err < 0.0) err = -err;
            check(err <= 0.0075, "R5 frequency", int'(f_est), int'(hz));
        end
        if (is_col) check(pk >= 1110 && pk <= 1134, "R3/R6 column peak", pk, 1133);
        else        check(pk >= 880 && pk <= 901, "R2/R6 row peak", pk, 900);
        if (is_col) col_rec[idx][REC_N-1] = col_rec[idx][REC_N-1];
        if (is_col) peak_col[idx] = pk; else peak_row[idx] = pk;
    endtask

    int peak_row [4];
    int peak_col [4];

    task automatic dual(input logic [4:0] c, input int r, input int cc);
        load_code(c);
        for (int k = 0; k < REC_N; k++) exp_q.push_back(row_rec[r][k] + col_rec[cc][k]);
        run_compare();   // R1
    endtask

    task automatic silent(input logic [4:0] c);
        load_code(c);
        for (int k = 0; k < 32; k++) exp_q.push_back(0);
        run_compare();   // R4
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(sample_o == 0, "R11 reset sample", int'(sample_o), 0);
        check(valid_o == 0, "R11 reset valid", int'(valid_o), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) exp_q.push_back(0);
        run_compare();   // R11 silent after reset

        // R8 cadence
        begin
            int gap;
            do @(negedge clk); while (!valid_o);
            gap = 0;
            do begin @(negedge clk); gap++; end while (!valid_o);
            check(gap == DIV, "R8 valid period", gap, DIV);
        end

        // R2 row-only, R3 column-only
        single_tone(5'b10000, 0, 0, 697.0);
        single_tone(5'b10001, 0, 1, 770.0);
        single_tone(5'b10010, 0, 2, 852.0);
        single_tone(5'b10011, 0, 3, 941.0);
        single_tone(5'b10100, 1, 0, 1209.0);
        single_tone(5'b10101, 1, 1, 1336.0);
        single_tone(5'b10110, 1, 2, 1477.0);
        single_tone(5'b10111, 1, 3, 1633.0);

        // R6 pre-emphasis ratio
        for (int i = 0; i < 4; i++) begin
            real ratio;
            ratio = real'(peak_col[i]) / real'(peak_row[i]);
            check(ratio >= 1.122 && ratio <= 1.413, "R6 column/row ratio x1000",
                  int'(ratio * 1000.0), 1259);
        end

        // R1 all sixteen dual codes
        dual(5'b00001, 0, 0); dual(5'b00010, 0, 1); dual(5'b00011, 0, 2);
        dual(5'b00100, 1, 0); dual(5'b00101, 1, 1); dual(5'b00110, 1, 2);
        dual(5'b00111, 2, 0); dual(5'b01000, 2, 1); dual(5'b01001, 2, 2);
        dual(5'b01010, 3, 1); dual(5'b01011, 3, 0); dual(5'b01100, 3, 2);
        dual(5'b01101, 0, 3); dual(5'b01110, 1, 3); dual(5'b01111, 2, 3);
        dual(5'b00000, 3, 3);

        // R4 off code and unused codes
        for (int c = 24; c < 32; c++) silent(5'(c));

        // R10 enable gating and zero-phase restart
        load_code(5'b00101);
        for (int k = 0; k < 4; k++) exp_q.push_back(row_rec[1][k] + col_rec[1][k]);
        run_compare();
        en_i = 1'b0;
        for (int k = 0; k < 16; k++) exp_q.push_back(0);
        run_compare();
        en_i = 1'b1;
        for (int k = 0; k < 32; k++) exp_q.push_back(row_rec[1][k] + col_rec[1][k]);
        run_compare();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule